// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous request port to an asynchronous low-power static RAM with a 16-bit data bus. It runs one single read or one single write at a time. For each access it drives the two chip selects (one active low, one active high), the write enable, the output enable, and the byte-lane enables for the low and high bytes. The bidirectional data bus is split into an output value, a drive-enable, and an input value. The tristate buffer sits at the pad ring.

Each phase of an access has a fixed length in clock cycles. That length comes from a nanosecond limit rounded up to whole clock periods, plus one cycle of margin. A read keeps output enable low long enough to cover both the address and the output-enable access times. A write has three phases in order:
1. A bus-release phase. The chip is selected but write enable and output enable stay high and the bus is not driven.
2. A write pulse. Write enable is low and the byte enables are on.
3. A recovery cycle. Data stays on the bus after write enable rises.

A requester raises `reqValid` with the address, data, byte mask and direction, and holds it until `ack` is seen. It lowers `reqValid` during the cycle in which `ack` is high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, the pins are in standby: `memCsN`=1, `memCs`=0, `memWeN`=1, `memOeN`=1, `memLbN`=1, `memUbN`=1, `memDqOe`=0, and `ack`=0.
- R2: A read holds the chip selected with `memOeN`=0 and `memWeN`=1 for exactly RD_CYC consecutive cycles. RD_CYC is ceil(max(cycle time, address access)/clock)+1, which is 7 by default. `rdData` holds the bus value sampled at the end of that window.
- R3: `reqMask` bit 0 enables bits 7:0 through `memLbN`, and bit 1 enables bits 15:8 through `memUbN`. Both pins are active low and are on only during the read window or the write pulse. A lane that the mask leaves off reads back as zero in `rdData`.
- R4: A write holds `memWeN` low for exactly WP_CYC cycles. WP_CYC is ceil(max(write pulse, data setup)/clock)+1, which is 5 by default. `memDqOe` is 1 throughout the pulse and during the following recovery cycle.
- R5: Before write enable falls, the chip is selected for exactly HZ_CYC cycles with the bus undriven and both enables high. HZ_CYC is ceil(turn-off time/clock)+1, which is 3 by default.
- R6: `memDqOe` and a low `memOeN` are never present in the same cycle.
- R7: `memAddr` stays constant while the chip is selected, and `memDqOut` stays constant while write enable is low. This holds even if the request inputs change after the request is accepted.
- R8: `ack` is high for exactly one cycle per access. It rises only after the pins have returned to standby.
- R9: A write whose `reqMask` is 0 creates no write overlap, so the memory contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; sampled only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | 2 | Byte-lane mask (bit 0 low byte, bit 1 high byte) |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Captured read data, valid when ack is high |
| memAddr | output | ADDR_W | Memory address |
| memCsN | output | 1 | Chip select, active low |
| memCs | output | 1 | Chip select, active high |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Low byte enable, active low |
| memUbN | output | 1 | High byte enable, active low |
| memDqOut | output | DATA_W | Data driven toward the memory |
| memDqOe | output | 1 | Drive enable for the data bus |
| memDqIn | input | DATA_W | Data bus value from the pads |

## Verification
The bench runs a behavioural memory model whose read data is garbage until output enable has been low for the full access time. This makes a shortened read window visible as wrong data. Writes are tried with all three non-zero masks to the same word, and the reads that follow separate the lane-to-pin mapping from a whole-word write. A mask-zero write and a write to a second address show that no stray overlap occurs and that addresses are isolated. Single-lane reads show that unselected lanes return zero. An address change during an access and a reset during a read check that the pins hold steady and that they fall back to standby.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSET   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREC   = 3'd4,
    ST_DONE   = 3'd5
  } ctrl_state_t;

  // Strobes from control to datapath, registered onto the pins one cycle later
  typedef struct packed {
    logic load;     // latch request fields
    logic sel;      // both chip selects active
    logic rdEn;     // output enable active
    logic wrEn;     // write enable active
    logic byteEn;   // byte lanes enabled per mask
    logic drive;    // drive data bus
    logic capture;  // last read cycle: sample bus at end of window
    logic ack;      // completion
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // whole clocks covering ns, plus one margin cycle
  function automatic int cyclesFor(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs + 1;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int HZ_CYC  = 3,
  parameter int WP_CYC  = 5,
  parameter int REC_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t stb
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, HZ_CYC), maxOf(WP_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic lastCyc;

  assign lastCyc = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = lastCyc ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        cntNxt = '0;
        if (reqValid) begin
          stateNxt = reqWrite ? ST_WSET : ST_READ;
          cntNxt   = reqWrite ? CNT_W'(HZ_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ:   if (lastCyc) stateNxt = ST_DONE;
      ST_WSET:   if (lastCyc) begin stateNxt = ST_WPULSE; cntNxt = CNT_W'(WP_CYC - 1);  end
      ST_WPULSE: if (lastCyc) begin stateNxt = ST_WREC;   cntNxt = CNT_W'(REC_CYC - 1); end
      ST_WREC:   if (lastCyc) stateNxt = ST_DONE;
      ST_DONE:   stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.load    = (state == ST_IDLE) && reqValid;
    stb.sel     = (state == ST_READ) || (state == ST_WSET) ||
                  (state == ST_WPULSE) || (state == ST_WREC);
    stb.rdEn    = (state == ST_READ);
    stb.wrEn    = (state == ST_WPULSE);
    stb.byteEn  = (state == ST_READ) || (state == ST_WPULSE);
    stb.drive   = (state == ST_WPULSE) || (state == ST_WREC);
    stb.capture = (state == ST_READ) && lastCyc;
    stb.ack     = (state == ST_DONE);
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqMask,
  input  logic [DATA_W-1:0]     memDqIn,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memCsN,
  output logic                  memCs,
  output logic                  memWeN,
  output logic                  memOeN,
  output logic [DATA_W/8-1:0]   memBeN,
  output logic [DATA_W-1:0]     memDqOut,
  output logic                  memDqOe,
  output logic [DATA_W-1:0]     rdData,
  output logic                  ack
);

  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BYTES-1:0]  maskQ;
  logic              capQ;

  // request holding registers: stable for the whole access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (stb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  // pin registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCsN  <= 1'b1;
      memCs   <= 1'b0;
      memWeN  <= 1'b1;
      memOeN  <= 1'b1;
      memDqOe <= 1'b0;
      capQ    <= 1'b0;
      ack     <= 1'b0;
    end else begin
      memCsN  <= !stb.sel;
      memCs   <= stb.sel;
      memWeN  <= !stb.wrEn;
      memOeN  <= !stb.rdEn;
      memDqOe <= stb.drive;
      capQ    <= stb.capture;
      ack     <= stb.ack;
    end
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic       laneBeN;
    logic [7:0] laneRd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneBeN <= 1'b1;
        laneRd  <= '0;
      end else begin
        laneBeN <= !(stb.byteEn && maskQ[i]);
        if (capQ) laneRd <= maskQ[i] ? memDqIn[i*8 +: 8] : 8'h00;
      end
    end

    assign memBeN[i]        = laneBeN;
    assign rdData[i*8 +: 8] = laneRd;
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int T_RC_NS = 55,   // minimum access cycle
  parameter int T_AA_NS = 55,   // address to data
  parameter int T_OE_NS = 25,   // output enable to data
  parameter int T_WP_NS = 40,   // write pulse
  parameter int T_DW_NS = 25,   // data valid before write end
  parameter int T_HZ_NS = 20,   // memory output turn-off
  parameter int T_WR_NS = 0     // write recovery
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memCs,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC  = cyclesFor(maxOf(maxOf(T_RC_NS, T_AA_NS), T_OE_NS), CLK_NS);
  localparam int HZ_CYC  = cyclesFor(T_HZ_NS, CLK_NS);
  localparam int WP_CYC  = cyclesFor(maxOf(T_WP_NS, T_DW_NS), CLK_NS);
  localparam int REC_CYC = cyclesFor(T_WR_NS, CLK_NS);

  strobe_t    stb;
  logic [1:0] beN;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .HZ_CYC (HZ_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .stb     (stb)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCsN  (memCsN),
    .memCs   (memCs),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memBeN  (beN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rdData  (rdData),
    .ack     (ack)
  );

  assign memLbN = beN[0];
  assign memUbN = beN[1];

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ack,
  input logic              memCsN,
  input logic              memCs,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDqOut
);

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqOe && !memOeN));

  // R4
  we_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memCs && memOeN && memDqOe));

  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memDqOut));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R8
  ack_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (memCsN && !memCs && memWeN && memOeN && !memDqOe));

  // R5
  drive_after_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> ($past(!memCsN) && $past(memOeN)));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ack     (ack),
  .memCsN  (memCsN),
  .memCs   (memCs),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memDqOe (memDqOe),
  .memAddr (memAddr),
  .memDqOut(memDqOut)
);

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

  localparam int ADDR_W  = 21;
  localparam int DATA_W  = 16;
  localparam int RD_EXP  = 7;   // ceil(55/10)+1
  localparam int WP_EXP  = 5;   // ceil(40/10)+1
  localparam int HZ_EXP  = 3;   // ceil(20/10)+1
  localparam int ACC_MIN = 6;   // model: cycles of output enable before data is valid
  localparam int NVEC    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [1:0] reqMask = '0;
  logic ack, memCsN, memCs, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [DATA_W-1:0] rdData, memDqOut, memDqIn;
  logic [ADDR_W-1:0] memAddr;

  always #5 clk = ~clk;

  sram_bus_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .ack(ack), .rdData(rdData), .memAddr(memAddr), .memCsN(memCsN),
    .memCs(memCs), .memWeN(memWeN), .memOeN(memOeN), .memLbN(memLbN),
    .memUbN(memUbN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // ---------------- memory model and monitors ----------------
  logic [15:0] mem [16];
  logic selected, rdAct, wrAct;
  int rdRun, lastRd, wrRun, lastWr, selPre, lastSetup;
  int contention, addrMoves, undriven;
  logic [3:0] pA; logic [15:0] pD; logic pLb, pUb;
  logic [ADDR_W-1:0] prevAddr; logic prevSel;

  assign selected = !memCsN && memCs;
  assign rdAct = selected && !memOeN && memWeN && (!memLbN || !memUbN);
  assign wrAct = selected && !memWeN && (!memLbN || !memUbN);
  assign memDqIn = (rdAct && rdRun >= ACC_MIN) ?
    {(!memUbN ? mem[memAddr[3:0]][15:8] : 8'h00), (!memLbN ? mem[memAddr[3:0]][7:0] : 8'h00)}
    : 16'hDEAD;

  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdRun <= 0; lastRd <= 0; wrRun <= 0; lastWr <= 0; selPre <= 0; lastSetup <= 0;
      prevSel <= 1'b0; prevAddr <= '0;
    end else begin
      if (rdAct) rdRun <= rdRun + 1;
      else if (rdRun != 0) begin lastRd <= rdRun; rdRun <= 0; end
      if (wrAct) begin
        if (wrRun == 0) lastSetup <= selPre;
        wrRun <= wrRun + 1;
        pA <= memAddr[3:0]; pD <= memDqOut; pLb <= !memLbN; pUb <= !memUbN;
        if (!memDqOe) undriven <= undriven + 1;
      end else if (wrRun != 0) begin
        if (pLb) mem[pA][7:0]  <= pD[7:0];
        if (pUb) mem[pA][15:8] <= pD[15:8];
        lastWr <= wrRun; wrRun <= 0;
      end
      if (!selected) selPre <= 0;
      else if (memWeN && memOeN && !memDqOe && wrRun == 0) selPre <= selPre + 1;
      if (memDqOe && !memOeN) contention <= contention + 1;
      if (selected && prevSel && memAddr != prevAddr) addrMoves <= addrMoves + 1;
      prevSel <= selected; prevAddr <= memAddr;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkStandby(input string req);
    chk(memCsN && !memCs && memWeN && memOeN && memLbN && memUbN && !memDqOe && !ack, req,
        {24'h0, memCsN, memCs, memWeN, memOeN, memLbN, memUbN, memDqOe, ack},
        {24'h0, 8'b10111100});
  endtask

  // run one access; returns captured data
  task automatic runTxn(input bit wr, input logic [3:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] got, output bit seen);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(a); reqWdata = d; reqMask = m;
    seen = 0; n = 0;
    while (!seen && n < 100) begin
      @(negedge clk);
      n++;
      if (ack) seen = 1;
    end
    got = rdData;
    reqValid = 1'b0;
    @(negedge clk);
    chk(!ack, "R8 ack single cycle", {31'h0, ack}, 32'h0);
  endtask

  // {wr, addr[3:0], wdata[15:0], mask[1:0], expect[15:0]}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 4'd3, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 4'd3, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 4'd3, 16'h55AB, 2'b01, 16'h0000},
    {1'b0, 4'd3, 16'h0000, 2'b11, 16'h12AB},
    {1'b1, 4'd3, 16'hCD77, 2'b10, 16'h0000},
    {1'b0, 4'd3, 16'h0000, 2'b11, 16'hCDAB},
    {1'b1, 4'd3, 16'hFFFF, 2'b00, 16'h0000},
    {1'b0, 4'd3, 16'h0000, 2'b11, 16'hCDAB},
    {1'b1, 4'd5, 16'hA5C3, 2'b11, 16'h0000},
    {1'b0, 4'd5, 16'h0000, 2'b01, 16'h00C3},
    {1'b0, 4'd5, 16'h0000, 2'b10, 16'hA500},
    {1'b0, 4'd3, 16'h0000, 2'b11, 16'hCDAB}
  };

  initial begin
    logic [15:0] got;
    bit seen;
    contention = 0; addrMoves = 0; undriven = 0;
    repeat (3) @(negedge clk);
    checkStandby("R1 during reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkStandby("R1 after reset");

    for (int v = 0; v < NVEC; v++) begin
      logic [38:0] e;
      e = VEC[v];
      runTxn(e[38], e[37:34], e[33:18], e[17:16], got, seen);
      chk(seen, "R8 ack arrives", {31'h0, seen}, 32'h1);
      if (e[38]) begin
        if (e[17:16] != 2'b00) begin
          chk(lastWr == WP_EXP, "R4 write pulse length", lastWr, WP_EXP);
          chk(lastSetup == HZ_EXP, "R5 bus release before write", lastSetup, HZ_EXP);
        end
      end else begin
        chk(lastRd == RD_EXP, "R2 read window length", lastRd, RD_EXP);
        if (e[17:16] == 2'b11)
          chk(got == e[15:0], "R2 R9 read data", {16'h0, got}, {16'h0, e[15:0]});
        else
          chk(got == e[15:0], "R3 lane read data", {16'h0, got}, {16'h0, e[15:0]});
      end
    end

    // R7: request inputs change after acceptance
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ADDR_W'(4'd7); reqWdata = 16'h0F0F; reqMask = 2'b11;
    @(negedge clk);
    reqAddr = ADDR_W'(4'd9); reqWdata = 16'hBEEF;
    while (!ack) @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    runTxn(1'b0, 4'd7, 16'h0, 2'b11, got, seen);
    chk(got == 16'h0F0F, "R7 latched write data/address", {16'h0, got}, 32'h0F0F);
    runTxn(1'b0, 4'd9, 16'h0, 2'b11, got, seen);
    chk(got == 16'h0000, "R7 changed address untouched", {16'h0, got}, 32'h0);

    // R1: reset in the middle of a read
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = ADDR_W'(4'd3); reqMask = 2'b11;
    repeat (4) @(negedge clk);
    chk(!memOeN, "R2 read in progress", {31'h0, memOeN}, 32'h0);
    rstN = 1'b0; reqValid = 1'b0;
    #1;
    checkStandby("R1 reset mid-read");
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkStandby("R1 idle after reset");
    runTxn(1'b0, 4'd3, 16'h0, 2'b11, got, seen);
    chk(got == 16'hCDAB, "R2 read after reset", {16'h0, got}, 32'hCDAB);

    chk(contention == 0, "R6 bus contention cycles", contention, 0);
    chk(addrMoves == 0, "R7 address moves while selected", addrMoves, 0);
    chk(undriven == 0, "R4 undriven write cycles", undriven, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule